// File: doc/BRIEF.md
# Address-Sequence Command Detector

This block sits beside an asynchronous-memory style bus whose control strobes and address have already been brought into the system clock domain. It watches for a hidden command: six qualified reads, back to back, from a fixed series of addresses. The first five addresses form a common prefix. The sixth address picks one of four commands: nonvolatile store, nonvolatile recall, disable automatic store, or enable automatic store.

When a series completes, the block emits a single-cycle pulse with a two-bit command code. Any write, or any read from an address that does not continue the series, throws the partial series away. The block does not perform the memory access. It does not carry out the store or recall, and it does no analog timing. While the store/recall controller reports busy, the block stays idle and ignores all bus activity.

Top module: `cmdseq_detect`

## Requirements
- R1: After synchronous reset, `cmd_valid_o` is 0 and the sequence state is idle. A run made only of prefix steps two to five followed by a command address issues no command.
- R2: Consider five qualified reads from 0x0E38, 0x31C7, 0x03E0, 0x3C1F and 0x303F, in that order, followed by a sixth qualified read from a command address. This raises `cmd_valid_o` for exactly one cycle. The pulse appears in the cycle after the clock edge that samples the sixth qualifying edge.
- R3: The sixth address sets `cmd_code_o`. 0x0FC0 gives 0 (store). 0x0C63 gives 1 (recall). 0x0B45 gives 2 (automatic store off). 0x0B46 gives 3 (automatic store on).
- R4: A read counts only on a qualifying edge with write enable high. The qualifying edge is either chip enable falling while output enable is low, or output enable falling while chip enable is low. Levels without such an edge, and chip enable falling while output enable is high, count for nothing.
- R5: Each qualifying edge advances the series by at most one step, however long the strobe stays low.
- R6: Any write (chip enable low with write enable low) discards the partial series, even when the write goes to the expected address. No command follows.
- R7: A qualified read from an address that does not continue the series discards it. No command follows.
- R8: Address bits 1 and 0 are ignored for the five prefix steps and for the store and recall codes. The two automatic-store codes are compared on all 15 bits, so 0x0B44 and 0x0B47 issue nothing.
- R9: After a discard, a qualified read from 0x0E38 counts as step one of a fresh series.
- R10: While `busy_i` is high, the series is cleared and qualified reads are ignored. No command pulse is issued, including when busy rises in the same cycle as the sixth read.
- R11: Two complete series in a row each issue their own command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| busy_i | input | 1 | Store/recall controller busy; clears and blocks the detector |
| ce_n_i | input | 1 | Synchronised chip enable, active low |
| oe_n_i | input | 1 | Synchronised output enable, active low |
| we_n_i | input | 1 | Synchronised write enable, active low |
| addr_i | input | 15 | Synchronised bus address |
| cmd_valid_o | output | 1 | One-cycle command pulse |
| cmd_code_o | output | 2 | Command code, valid with the pulse |

## Verification
The sixth qualifying read and a rising busy can land on the same clock edge. The bench provokes this by raising `busy_i` at the very edge where chip enable falls on the completing address. It judges the outcome by counting pulses, and expects none. It then runs a clean series and expects exactly one pulse, which shows that busy also cleared the state rather than leaving a step half-taken. A sweep of every sixth address below 0x1000 and a sweep of single-bit flips on each prefix step check the decode arithmetically.

// File: rtl/cmdseq_pkg.sv
`timescale 1ns/1ps
package cmdseq_pkg;
  localparam int CS_ADDR_W   = 15;
  localparam int CS_PREFIX_N = 5;

  typedef enum logic [1:0] {
    CMD_STORE    = 2'd0,
    CMD_RECALL   = 2'd1,
    CMD_AUTO_OFF = 2'd2,
    CMD_AUTO_ON  = 2'd3
  } cmd_code_e;

  localparam logic [CS_ADDR_W-1:0] ADR_STORE    = 15'h0FC0;
  localparam logic [CS_ADDR_W-1:0] ADR_RECALL   = 15'h0C63;
  localparam logic [CS_ADDR_W-1:0] ADR_AUTO_OFF = 15'h0B45;
  localparam logic [CS_ADDR_W-1:0] ADR_AUTO_ON  = 15'h0B46;

  // Order matters: step index i expects prefix_addr(i).
  function automatic logic [CS_ADDR_W-1:0] prefix_addr(input int idx);
    case (idx)
      0:       prefix_addr = 15'h0E38;
      1:       prefix_addr = 15'h31C7;
      2:       prefix_addr = 15'h03E0;
      3:       prefix_addr = 15'h3C1F;
      4:       prefix_addr = 15'h303F;
      default: prefix_addr = '0;
    endcase
  endfunction
endpackage

// File: rtl/cmdseq_strobe.sv
`timescale 1ns/1ps
module cmdseq_strobe (
  input  logic clk,
  input  logic rst,
  input  logic ce_n_i,
  input  logic oe_n_i,
  input  logic we_n_i,
  output logic rd_stb_o,
  output logic wr_evt_o
);
  logic ce_q, oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_q <= 1'b1;
      oe_q <= 1'b1;
    end else begin
      ce_q <= ce_n_i;
      oe_q <= oe_n_i;
    end
  end

  logic ce_fall, oe_fall;
  assign ce_fall  = ce_q & ~ce_n_i;
  assign oe_fall  = oe_q & ~oe_n_i;
  assign rd_stb_o = we_n_i & ((ce_fall & ~oe_n_i) | (oe_fall & ~ce_n_i));
  assign wr_evt_o = ~ce_n_i & ~we_n_i;

  // R5: one strobe per edge, never on two cycles in a row
  a_r5_single_edge: assert property (@(posedge clk) disable iff (rst)
    rd_stb_o |=> !rd_stb_o);
  // R4: a strobe only ever accompanies an enabled read bus state
  a_r4_read_state: assert property (@(posedge clk) disable iff (rst)
    rd_stb_o |-> (!ce_n_i && !oe_n_i && we_n_i));
  // R6: reads and writes never coincide
  a_r6_disjoint: assert property (@(posedge clk) disable iff (rst)
    wr_evt_o |-> !rd_stb_o);
endmodule

// File: rtl/cmdseq_match.sv
`timescale 1ns/1ps
module cmdseq_match
  import cmdseq_pkg::*;
#(
  parameter int IGN_LSB = 2
) (
  input  logic [CS_ADDR_W-1:0]   addr_i,
  output logic [CS_PREFIX_N-1:0] pre_hit_o,
  output logic                   cmd_hit_o,
  output cmd_code_e              cmd_code_o
);
  localparam int HI = CS_ADDR_W - 1;

  for (genvar g = 0; g < CS_PREFIX_N; g++) begin : g_pre
    localparam logic [CS_ADDR_W-1:0] PFX = prefix_addr(g);
    assign pre_hit_o[g] = (addr_i[HI:IGN_LSB] == PFX[HI:IGN_LSB]);
  end

  logic hit_st, hit_rc, hit_off, hit_on;
  assign hit_st  = (addr_i[HI:IGN_LSB] == ADR_STORE[HI:IGN_LSB]);
  assign hit_rc  = (addr_i[HI:IGN_LSB] == ADR_RECALL[HI:IGN_LSB]);
  // the two automatic-store codes share the upper bits: full compare
  assign hit_off = (addr_i == ADR_AUTO_OFF);
  assign hit_on  = (addr_i == ADR_AUTO_ON);

  always_comb begin
    cmd_hit_o  = hit_st | hit_rc | hit_off | hit_on;
    cmd_code_o = CMD_STORE;
    if (hit_rc)       cmd_code_o = CMD_RECALL;
    else if (hit_off) cmd_code_o = CMD_AUTO_OFF;
    else if (hit_on)  cmd_code_o = CMD_AUTO_ON;
  end
endmodule

// File: rtl/cmdseq_fsm.sv
`timescale 1ns/1ps
module cmdseq_fsm
  import cmdseq_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   busy_i,
  input  logic                   rd_stb_i,
  input  logic                   wr_evt_i,
  input  logic [CS_PREFIX_N-1:0] pre_hit_i,
  input  logic                   cmd_hit_i,
  input  cmd_code_e              cmd_code_i,
  output logic                   cmd_valid_o,
  output cmd_code_e              cmd_code_o
);
  localparam int STEP_W = $clog2(CS_PREFIX_N + 1);
  localparam int EXT_N  = 2 ** STEP_W;
  localparam logic [STEP_W-1:0] LAST = STEP_W'(CS_PREFIX_N);

  logic [STEP_W-1:0] step_q, step_d;
  logic [EXT_N-1:0]  hit_ext;
  logic              valid_d;
  cmd_code_e         code_d;

  assign hit_ext = {{(EXT_N - CS_PREFIX_N){1'b0}}, pre_hit_i};

  always_comb begin
    step_d  = step_q;
    valid_d = 1'b0;
    code_d  = cmd_code_o;
    if (busy_i || wr_evt_i) begin
      step_d = '0;
    end else if (rd_stb_i) begin
      if (step_q == LAST && cmd_hit_i) begin
        valid_d = 1'b1;
        code_d  = cmd_code_i;
        step_d  = '0;
      end else if (step_q != LAST && hit_ext[step_q]) begin
        step_d = step_q + 1'b1;
      end else begin
        step_d = pre_hit_i[0] ? STEP_W'(1) : '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q      <= '0;
      cmd_valid_o <= 1'b0;
      cmd_code_o  <= CMD_STORE;
    end else begin
      step_q      <= step_d;
      cmd_valid_o <= valid_d;
      cmd_code_o  <= code_d;
    end
  end

  // R2: the pulse lasts one cycle
  a_r2_one_cycle: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_o |=> !cmd_valid_o);
  // R2: a pulse follows a strobe on a command address
  a_r2_from_strobe: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_o |-> $past(rd_stb_i && cmd_hit_i));
  // R10: busy clears the series and blocks pulses
  a_r10_busy_blocks: assert property (@(posedge clk) disable iff (rst)
    busy_i |=> (!cmd_valid_o && step_q == '0));
  // R6: a write leaves the detector idle
  a_r6_write_clears: assert property (@(posedge clk) disable iff (rst)
    wr_evt_i |=> (!cmd_valid_o && step_q == '0));
  // R1: step never leaves its legal range
  a_r1_step_range: assert property (@(posedge clk) disable iff (rst)
    step_q <= LAST);
endmodule

// File: rtl/cmdseq_detect.sv
`timescale 1ns/1ps
module cmdseq_detect
  import cmdseq_pkg::*;
#(
  parameter int IGN_LSB = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        busy_i,
  input  logic        ce_n_i,
  input  logic        oe_n_i,
  input  logic        we_n_i,
  input  logic [14:0] addr_i,
  output logic        cmd_valid_o,
  output logic [1:0]  cmd_code_o
);
  logic                   rd_stb, wr_evt, cmd_hit;
  logic [CS_PREFIX_N-1:0] pre_hit;
  cmd_code_e              hit_code, out_code;

  cmdseq_strobe i_strobe (
    .clk(clk), .rst(rst), .ce_n_i(ce_n_i), .oe_n_i(oe_n_i), .we_n_i(we_n_i),
    .rd_stb_o(rd_stb), .wr_evt_o(wr_evt)
  );

  cmdseq_match #(.IGN_LSB(IGN_LSB)) i_match (
    .addr_i(addr_i), .pre_hit_o(pre_hit), .cmd_hit_o(cmd_hit),
    .cmd_code_o(hit_code)
  );

  cmdseq_fsm i_fsm (
    .clk(clk), .rst(rst), .busy_i(busy_i), .rd_stb_i(rd_stb),
    .wr_evt_i(wr_evt), .pre_hit_i(pre_hit), .cmd_hit_i(cmd_hit),
    .cmd_code_i(hit_code), .cmd_valid_o(cmd_valid_o), .cmd_code_o(out_code)
  );

  assign cmd_code_o = out_code;
endmodule

// File: tb/test_cmdseq_detect.sv
`timescale 1ns/1ps
module test_cmdseq_detect;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busy = 1'b0;
  logic        ce_n = 1'b1, oe_n = 1'b0, we_n = 1'b1;
  logic [14:0] addr = '0;
  logic        cmd_valid;
  logic [1:0]  cmd_code;

  int n_chk = 0, n_bad = 0, n_pulse = 0, last_code = -1, base = 0;

  always #2 clk = ~clk;

  cmdseq_detect i_cmdseq_detect (
    .clk(clk), .rst(rst), .busy_i(busy), .ce_n_i(ce_n), .oe_n_i(oe_n),
    .we_n_i(we_n), .addr_i(addr), .cmd_valid_o(cmd_valid), .cmd_code_o(cmd_code)
  );

  always @(negedge clk) if (cmd_valid) begin
    n_pulse++;
    last_code = int'(cmd_code);
  end

  localparam logic [14:0] P0 = 15'h0E38, P1 = 15'h31C7, P2 = 15'h03E0,
                          P3 = 15'h3C1F, P4 = 15'h303F;

  function automatic logic [14:0] pfx(input int i);
    case (i) 0: pfx = P0; 1: pfx = P1; 2: pfx = P2; 3: pfx = P3; default: pfx = P4; endcase
  endfunction

  // expected code from the requirement arithmetic, -1 for none
  function automatic int exp_code(input logic [14:0] a);
    if ((a >> 2) == (15'h0FC0 >> 2)) exp_code = 0;
    else if ((a >> 2) == (15'h0C63 >> 2)) exp_code = 1;
    else if (a == 15'h0B45) exp_code = 2;
    else if (a == 15'h0B46) exp_code = 3;
    else exp_code = -1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // mode 0: chip-enable controlled, mode 1: output-enable controlled
  task automatic rd(input logic [14:0] a, input int mode = 0, input int hold = 1);
    if (mode == 0) begin
      @(negedge clk); addr = a; ce_n = 1'b0;
      repeat (hold) @(negedge clk);
      ce_n = 1'b1;
    end else begin
      @(negedge clk); oe_n = 1'b1;
      @(negedge clk); addr = a; ce_n = 1'b0;
      @(negedge clk); oe_n = 1'b0;
      repeat (hold) @(negedge clk);
      ce_n = 1'b1;
    end
  endtask

  task automatic wr(input logic [14:0] a);
    @(negedge clk); addr = a; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic seq(input logic [14:0] last, input int mode = 0);
    for (int i = 0; i < 5; i++) rd(pfx(i), mode);
    rd(last, mode);
  endtask

  task automatic mark(); base = n_pulse; last_code = -1; endtask

  // exp < 0: no pulse; else one pulse with that code
  task automatic expect_cmd(input string req, input int exp);
    repeat (2) @(negedge clk);
    chk(req, n_pulse - base, (exp < 0) ? 0 : 1);
    if (exp >= 0) chk(req, last_code, exp);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R2: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset pulse", int'(cmd_valid), 0);
    // R1: tail without first step does nothing
    mark(); for (int i = 1; i < 5; i++) rd(pfx(i)); rd(15'h0FC0);
    expect_cmd("R1 tail only", -1);

    // R2 R3: each code, chip-enable controlled
    mark(); seq(15'h0FC0); expect_cmd("R3 store", 0);
    mark(); seq(15'h0C63); expect_cmd("R3 recall", 1);
    mark(); seq(15'h0B45); expect_cmd("R3 auto off", 2);
    mark(); seq(15'h0B46); expect_cmd("R3 auto on", 3);
    // R2: timing — pulse visible at first negedge after the sixth edge
    mark();
    for (int i = 0; i < 5; i++) rd(pfx(i));
    @(negedge clk); addr = 15'h0FC0; ce_n = 1'b0;
    @(negedge clk);
    chk("R2 pulse cycle", int'(cmd_valid), 1);
    @(negedge clk);
    chk("R2 pulse width", int'(cmd_valid), 0);
    ce_n = 1'b1;

    // R4: output-enable controlled
    mark(); seq(15'h0C63, 1); expect_cmd("R4 oe controlled", 1);
    // R4: chip enable falling with oe high is no read
    mark();
    for (int i = 0; i < 2; i++) rd(pfx(i));
    @(negedge clk); oe_n = 1'b1;
    @(negedge clk); addr = P2; ce_n = 1'b0;
    @(negedge clk); ce_n = 1'b1;
    @(negedge clk); oe_n = 1'b0;
    rd(P3); rd(P4); rd(15'h0FC0);
    expect_cmd("R4 no edge", -1);

    // R5: long hold on step two counts once
    mark();
    rd(P0); rd(P1, 0, 9); rd(P2); rd(P3); rd(P4); rd(15'h0B46);
    expect_cmd("R5 long hold", 3);
    mark();
    rd(P0); rd(P1, 1, 7); rd(P2); rd(P3); rd(P4); rd(15'h0B45);
    expect_cmd("R5 long oe hold", 2);

    // R6: a write to the expected address aborts
    mark(); rd(P0); rd(P1); wr(P2); rd(P3); rd(P4); rd(15'h0FC0);
    expect_cmd("R6 write abort", -1);
    mark(); rd(P0); rd(P1); rd(P2); wr(P3); rd(P3); rd(P4); rd(15'h0FC0);
    expect_cmd("R6 write then resume", -1);

    // R7: wrong address aborts
    mark(); rd(P0); rd(P1); rd(15'h1234); rd(P2); rd(P3); rd(P4); rd(15'h0FC0);
    expect_cmd("R7 stray read", -1);

    // R9: restart at first prefix after abort
    mark(); rd(P0); rd(P1); rd(P2); rd(P0); rd(P1); rd(P2); rd(P3); rd(P4); rd(15'h0C63);
    expect_cmd("R9 restart", 1);

    // R10: busy mid-series
    mark(); rd(P0); rd(P1); rd(P2);
    @(negedge clk); busy = 1'b1; @(negedge clk); busy = 1'b0;
    rd(P3); rd(P4); rd(15'h0FC0);
    expect_cmd("R10 busy mid", -1);
    // R10: busy in the same cycle as the sixth read
    mark();
    for (int i = 0; i < 5; i++) rd(pfx(i));
    @(negedge clk); addr = 15'h0FC0; ce_n = 1'b0; busy = 1'b1;
    @(negedge clk); busy = 1'b0; ce_n = 1'b1;
    expect_cmd("R10 busy coincident", -1);
    mark(); seq(15'h0FC0); expect_cmd("R10 after busy", 0);
    // R10: series fully run during busy
    mark(); busy = 1'b1; seq(15'h0C63); busy = 1'b0;
    expect_cmd("R10 busy whole", -1);

    // R11: two series back to back
    mark(); seq(15'h0B45); seq(15'h0B46);
    repeat (2) @(negedge clk);
    chk("R11 two pulses", n_pulse - base, 2);
    chk("R11 last code", last_code, 3);

    // R8: low bits ignored on prefixes and store/recall
    mark(); rd(P0 ^ 15'h3); rd(P1 ^ 15'h1); rd(P2 ^ 15'h2); rd(P3); rd(P4 ^ 15'h3); rd(15'h0FC3);
    expect_cmd("R8 low bits", 0);
    mark(); seq(15'h0B44); expect_cmd("R8 0B44", -1);
    mark(); seq(15'h0B47); expect_cmd("R8 0B47", -1);

    // R8 R3: sweep of sixth address
    for (int a = 0; a < 4096; a++) begin
      mark(); seq(15'(a)); expect_cmd("R8 sweep", exp_code(15'(a)));
    end
    // R7 R8: single-bit flips on each prefix step
    for (int s = 0; s < 5; s++) begin
      for (int b = 0; b < 15; b++) begin
        mark();
        for (int i = 0; i < 5; i++) rd((i == s) ? (pfx(i) ^ (15'h1 << b)) : pfx(i));
        rd(15'h0C63);
        expect_cmd("R7 flip", (b < 2) ? 1 : -1);
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule